// File: doc/BRIEF.md
# Receiver AGC Gain-Index Controller

This block steers the gain index of a receive chain. Peak detectors report a high-threshold overload and whether enough peaks crossed their low threshold. A power detector asks for gain recovery. The controller turns these into single gain steps. Each step is clamped to a programmed window, and the block presents the resulting index together with a one-cycle strobe whenever the index moves.

A long decision counter runs while the controller is active. Each time it expires, the block pulses a detector-clear strobe and forgets any request it had been holding. Decreases and increases can each be applied in the cycle the request arrives, or held until the next expiry. After every real gain change, two timers start. A settling timer blocks further changes, and a blanking timer masks the peak detectors and drops their overload reports. When the receive path is switched on, an attack-hold interval passes before any decision is taken.

Configuration is captured only while the receive path is off, so a running loop never sees a half-updated setting. The attack step and recovery step are separate inputs. An optional gate discards recovery requests while the low-threshold peak count is high.

Top module: `rx_gain_ctrl`

## Requirements
- R1: While `rst_n` is low, `gain_idx` reads all ones and `gain_chg`, `det_reset` and `peak_det_en` are low. Once reset is released with `rx_en` low, `gain_idx` takes the captured maximum within two cycles and `peak_det_en` stays low.
- R2: Configuration inputs are captured on every clock while the controller is inactive (`rx_en` low). Changes made while `rx_en` is high have no effect until the controller is next inactive.
- R3: `rx_en` may be sampled high while inactive. With `cfg_attack` = A, the controller then holds for exactly A cycles. During the hold, `peak_det_en` is low, overloads are ignored and `gain_idx` does not move. Active operation starts after the hold, or directly when A = 0.
- R4: While active, with `cfg_period` = P (P = 0 acts as 1), `det_reset` pulses for one cycle in active cycles P-1, 2P-1, and so on, counting from cycle 0.
- R5: An accepted decrease lowers `gain_idx` by `cfg_step_dn`, clamped at `cfg_gain_min`. The new value and a one-cycle `gain_chg` appear one cycle after the deciding cycle.
- R6: An accepted increase from `pwr_up_req` raises `gain_idx` by `cfg_step_up`, clamped at `cfg_gain_max`, with the same one-cycle latency and strobe.
- R7: An accepted step that leaves the index unchanged, because it is already at the limit, produces no `gain_chg`, starts no settling and causes no blanking.
- R8: When a decrease and an increase are both wanted in the same cycle, the decrease is taken and the increase is discarded.
- R9: After a change, no further change is decided for `cfg_settle` = S cycles. A held overload therefore produces strobes exactly S+1 cycles apart.
- R10: After a change, `peak_det_en` is low for `cfg_blank` cycles, starting with the strobe cycle. Overloads arriving in those cycles are dropped and are not remembered.
- R11: With `cfg_veto_en` = 1, a `pwr_up_req` in a cycle where `peak_lo_enough` = 1 is discarded. With `cfg_veto_en` = 0, `peak_lo_enough` has no effect.
- R12: `cfg_sync` bit 0 governs decreases and bit 1 governs increases. A bit value of 1 applies the step at once. A bit value of 0 remembers the request and applies it in the expiry cycle, so `gain_chg` comes one cycle after `det_reset`. Remembered requests are dropped at every expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive path enable |
| cfg_gain_max | input | GAIN_W | Upper gain-index limit |
| cfg_gain_min | input | GAIN_W | Lower gain-index limit (must be below the maximum) |
| cfg_step_dn | input | STEP_W | Attack (decrease) step size |
| cfg_step_up | input | STEP_W | Recovery (increase) step size |
| cfg_blank | input | BLANK_W | Peak-detector blanking cycles after a change |
| cfg_period | input | PERIOD_W | Decision period in cycles |
| cfg_settle | input | SETTLE_W | Settling cycles after a change |
| cfg_attack | input | ATTACK_W | Hold cycles after the receive path is enabled |
| cfg_sync | input | 2 | Per-direction immediate (1) or deferred (0) select |
| cfg_veto_en | input | 1 | Enable the peak-count gate on recovery requests |
| peak_over_hi | input | 1 | High-threshold overload from the peak detectors |
| peak_lo_enough | input | 1 | Low-threshold peak count is sufficient |
| pwr_up_req | input | 1 | Gain increase request from the power detector |
| gain_idx | output | GAIN_W | Current gain index |
| gain_chg | output | 1 | One-cycle strobe on a gain change |
| det_reset | output | 1 | One-cycle detector-clear strobe at period expiry |
| peak_det_en | output | 1 | Peak detectors enabled (low while held or blanked) |

## Verification
In immediate mode, a request seen in one cycle yields the new `gain_idx` and `gain_chg` at the next falling edge. In deferred mode, the change lands one cycle after the `det_reset` pulse. `det_reset` and `peak_det_en` come straight from counter registers and are valid in the cycle they describe. Blanking covers the strobe cycle and the following `cfg_blank`-1 cycles. The bench drives and samples only on falling edges and keeps a running cycle count. Each expected gain value is queued before its stimulus, and the monitor pops it when a strobe appears. Strobes with no queued value, timing gaps between strobes, and the cycles of expiry and blanking are checked against counts derived from the requirements.

// File: rtl/rx_gain_pkg.sv
package rx_gain_pkg;

  // Controller phase
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ATTACK = 2'd1,
    ST_RUN    = 2'd2
  } agc_state_e;

  // Bit positions inside the per-direction sync select
  localparam int SYNC_DN_BIT = 0;
  localparam int SYNC_UP_BIT = 1;

endpackage

// File: rtl/rx_gain_dncnt.sv
// Loadable down-counter that saturates at zero.
module rx_gain_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         dec,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                      cnt_d = ld_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rx_gain_period.sv
// Free-running decision counter; expires every max(period,1) active cycles.
module rx_gain_period #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] period,
  output logic         expire
);

  logic [W-1:0] cnt_q, cnt_d, reload;

  assign reload = (period == '0) ? '0 : period - W'(1);

  always_comb begin
    if (!active || cnt_q == '0) cnt_d = reload;
    else                        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = active && (cnt_q == '0);

endmodule

// File: rtl/rx_gain_step.sv
// Computes the clamped gain index for one step in the chosen direction.
module rx_gain_step #(
  parameter int GAIN_W = 8,
  parameter int STEP_W = 4
) (
  input  logic [GAIN_W-1:0] gain,
  input  logic [STEP_W-1:0] step_dn,
  input  logic [STEP_W-1:0] step_up,
  input  logic              go_down,
  input  logic [GAIN_W-1:0] lim_lo,
  input  logic [GAIN_W-1:0] lim_hi,
  output logic [GAIN_W-1:0] next_gain
);

  localparam int XW = GAIN_W + 1;

  logic [XW-1:0] g_x, lo_x, hi_x, dn_x, up_x, lo_plus;

  always_comb begin
    g_x     = XW'(gain);
    lo_x    = XW'(lim_lo);
    hi_x    = XW'(lim_hi);
    dn_x    = XW'(step_dn);
    up_x    = XW'(step_up);
    lo_plus = lo_x + dn_x;
    if (go_down) begin
      next_gain = (g_x < lo_plus) ? lim_lo : GAIN_W'(g_x - dn_x);
    end else begin
      next_gain = ((g_x + up_x) > hi_x) ? lim_hi : GAIN_W'(g_x + up_x);
    end
  end

endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
  import rx_gain_pkg::*;
#(
  parameter int GAIN_W   = 8,
  parameter int STEP_W   = 4,
  parameter int BLANK_W  = 5,
  parameter int PERIOD_W = 22,
  parameter int SETTLE_W = 7,
  parameter int ATTACK_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic [GAIN_W-1:0]   cfg_gain_max,
  input  logic [GAIN_W-1:0]   cfg_gain_min,
  input  logic [STEP_W-1:0]   cfg_step_dn,
  input  logic [STEP_W-1:0]   cfg_step_up,
  input  logic [BLANK_W-1:0]  cfg_blank,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [ATTACK_W-1:0] cfg_attack,
  input  logic [1:0]          cfg_sync,
  input  logic                cfg_veto_en,
  input  logic                peak_over_hi,
  input  logic                peak_lo_enough,
  input  logic                pwr_up_req,
  output logic [GAIN_W-1:0]   gain_idx,
  output logic                gain_chg,
  output logic                det_reset,
  output logic                peak_det_en
);

  // Captured configuration (R2)
  logic [GAIN_W-1:0]   max_q, min_q;
  logic [STEP_W-1:0]   sdn_q, sup_q;
  logic [BLANK_W-1:0]  blank_q;
  logic [PERIOD_W-1:0] period_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [ATTACK_W-1:0] attack_q;
  logic [1:0]          sync_q;
  logic                veto_q;

  agc_state_e st_q, st_d;
  logic [GAIN_W-1:0] gain_q, gain_d, next_gain;
  logic chg_q, dn_pend_q, up_pend_q, dn_pend_d, up_pend_d;
  logic run, cfg_ld, expire;
  logic atk_zero, settle_zero, blank_zero;
  logic [ATTACK_W-1:0] atk_cnt;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [BLANK_W-1:0]  blank_cnt;
  logic hi_in, up_in, dn_want, up_want, dn_go, up_go, chg_now;

  assign run    = (st_q == ST_RUN);
  assign cfg_ld = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0; min_q <= '0; sdn_q <= '0; sup_q <= '0;
      blank_q <= '0; period_q <= '0; settle_q <= '0; attack_q <= '0;
      sync_q <= '0; veto_q <= 1'b0;
    end else if (cfg_ld) begin
      max_q <= cfg_gain_max; min_q <= cfg_gain_min;
      sdn_q <= cfg_step_dn;  sup_q <= cfg_step_up;
      blank_q <= cfg_blank;  period_q <= cfg_period;
      settle_q <= cfg_settle; attack_q <= cfg_attack;
      sync_q <= cfg_sync;    veto_q <= cfg_veto_en;
    end
  end

  // Phase sequencing (R3)
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (rx_en) st_d = (attack_q == '0) ? ST_RUN : ST_ATTACK;
      ST_ATTACK: if (!rx_en) st_d = ST_IDLE; else if (atk_zero) st_d = ST_RUN;
      ST_RUN:    if (!rx_en) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  rx_gain_dncnt #(.W(ATTACK_W)) u_attack (
    .clk(clk), .rst_n(rst_n),
    .ld(st_q == ST_IDLE), .dec(st_q == ST_ATTACK),
    .ld_val(attack_q - ATTACK_W'(1)),
    .cnt(atk_cnt), .zero(atk_zero)
  );

  rx_gain_dncnt #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .ld(chg_now || !run), .dec(1'b1),
    .ld_val(run ? settle_q : '0),
    .cnt(settle_cnt), .zero(settle_zero)
  );

  rx_gain_dncnt #(.W(BLANK_W)) u_blank (
    .clk(clk), .rst_n(rst_n),
    .ld(chg_now || !run), .dec(1'b1),
    .ld_val(run ? blank_q : '0),
    .cnt(blank_cnt), .zero(blank_zero)
  );

  rx_gain_period #(.W(PERIOD_W)) u_period (
    .clk(clk), .rst_n(rst_n),
    .active(run), .period(period_q), .expire(expire)
  );

  // Request arbitration (R8, R10, R11, R12)
  always_comb begin
    hi_in   = run && blank_zero && peak_over_hi;
    up_in   = run && pwr_up_req && !(veto_q && peak_lo_enough);
    dn_want = hi_in || dn_pend_q;
    up_want = (up_in || up_pend_q) && !dn_want;
    dn_go   = dn_want && settle_zero && (sync_q[SYNC_DN_BIT] || expire);
    up_go   = up_want && settle_zero && (sync_q[SYNC_UP_BIT] || expire);
    chg_now = (dn_go || up_go) && (next_gain != gain_q);
    dn_pend_d = run && !expire && !dn_go && dn_want;
    up_pend_d = run && !expire && !up_go && up_want;
    if (st_q == ST_IDLE) gain_d = max_q;
    else if (chg_now)    gain_d = next_gain;
    else                 gain_d = gain_q;
  end

  rx_gain_step #(.GAIN_W(GAIN_W), .STEP_W(STEP_W)) u_step (
    .gain(gain_q), .step_dn(sdn_q), .step_up(sup_q), .go_down(dn_want),
    .lim_lo(min_q), .lim_hi(max_q), .next_gain(next_gain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      gain_q    <= '1;
      chg_q     <= 1'b0;
      dn_pend_q <= 1'b0;
      up_pend_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      gain_q    <= gain_d;
      chg_q     <= chg_now;
      dn_pend_q <= dn_pend_d;
      up_pend_q <= up_pend_d;
    end
  end

  assign gain_idx    = gain_q;
  assign gain_chg    = chg_q;
  assign det_reset   = expire;
  assign peak_det_en = run && blank_zero;

  // Assertions
  assert_chg_moves_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx != $past(gain_idx)));

  assert_attack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ATTACK) |=> $stable(gain_q));

  assert_settle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt != '0) |=> !gain_chg);

  assert_blank_after_chg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_chg && blank_q != '0) |-> !peak_det_en);

  assert_period_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_reset && period_q > PERIOD_W'(1)) |=> !det_reset);

  assert_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx <= max_q && gain_idx >= min_q));

endmodule

// File: tb/test_rx_gain_ctrl.sv
module test_rx_gain_ctrl;

  logic clk = 1'b0;
  logic rst_n, rx_en;
  logic [7:0]  cfg_gain_max, cfg_gain_min;
  logic [3:0]  cfg_step_dn, cfg_step_up;
  logic [4:0]  cfg_blank;
  logic [21:0] cfg_period;
  logic [6:0]  cfg_settle;
  logic [5:0]  cfg_attack;
  logic [1:0]  cfg_sync;
  logic cfg_veto_en, peak_over_hi, peak_lo_enough, pwr_up_req;
  logic [7:0] gain_idx;
  logic gain_chg, det_reset, peak_det_en;

  rx_gain_ctrl i_rx_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .cfg_gain_max(cfg_gain_max), .cfg_gain_min(cfg_gain_min),
    .cfg_step_dn(cfg_step_dn), .cfg_step_up(cfg_step_up),
    .cfg_blank(cfg_blank), .cfg_period(cfg_period), .cfg_settle(cfg_settle),
    .cfg_attack(cfg_attack), .cfg_sync(cfg_sync), .cfg_veto_en(cfg_veto_en),
    .peak_over_hi(peak_over_hi), .peak_lo_enough(peak_lo_enough),
    .pwr_up_req(pwr_up_req),
    .gain_idx(gain_idx), .gain_chg(gain_chg), .det_reset(det_reset),
    .peak_det_en(peak_det_en)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct { int val; string req; } exp_t;
  exp_t exp_q[$];
  int   stamp_q[$];

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_chg(int v, string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: every strobe must match the next queued value
  always @(negedge clk) begin
    if (rst_n === 1'b1 && gain_chg === 1'b1) begin
      stamp_q.push_back(cyc);
      if (exp_q.size() == 0) begin
        chk("R7 unexpected gain_chg", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, int'(gain_idx), e.val);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // Setting A: window 190..200, immediate both directions
    rst_n = 1'b0; rx_en = 1'b0;
    cfg_gain_max = 8'd200; cfg_gain_min = 8'd190;
    cfg_step_dn = 4'd3; cfg_step_up = 4'd2;
    cfg_blank = 5'd2; cfg_period = 22'd20; cfg_settle = 7'd4;
    cfg_attack = 6'd3; cfg_sync = 2'b11; cfg_veto_en = 1'b1;
    peak_over_hi = 1'b0; peak_lo_enough = 1'b0; pwr_up_req = 1'b0;
    tick(2);
    chk("R1 reset gain", int'(gain_idx), 255);
    chk("R1 reset gain_chg", int'(gain_chg), 0);
    chk("R1 reset det_reset", int'(det_reset), 0);
    chk("R1 reset peak_det_en", int'(peak_det_en), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle gain", int'(gain_idx), 200);
    chk("R1 idle peak_det_en", int'(peak_det_en), 0);

    // Enable with overload held through the attack hold (R3)
    rx_en = 1'b1; peak_over_hi = 1'b1;
    tick(1); chk("R3 hold en c1", int'(peak_det_en), 0);
    tick(1); chk("R3 hold en c2", int'(peak_det_en), 0);
    tick(1); chk("R3 hold en c3", int'(peak_det_en), 0);
    chk("R3 hold gain", int'(gain_idx), 200);
    peak_over_hi = 1'b0;
    tick(1); chk("R3 run en", int'(peak_det_en), 1);
    chk("R3 run gain", int'(gain_idx), 200);

    // Decision period (R4): expiry at active cycles 19 and 39
    tick(18); chk("R4 before expiry", int'(det_reset), 0);
    tick(1);  chk("R4 first expiry", int'(det_reset), 1);
    tick(1);  chk("R4 after expiry", int'(det_reset), 0);
    tick(19); chk("R4 second expiry", int'(det_reset), 1);

    // Immediate decrease and blanking (R5, R10)
    tick(1);
    expect_chg(197, "R5 decrease");
    peak_over_hi = 1'b1;
    tick(1); chk("R10 blank c1", int'(peak_det_en), 0);
    tick(1); chk("R10 blank c2", int'(peak_det_en), 0);
    peak_over_hi = 1'b0;
    tick(1); chk("R10 blank over", int'(peak_det_en), 1);
    tick(9); chk("R10 blanked overload dropped", int'(gain_idx), 197);

    // Held overload: spacing and clamp at minimum (R9, R5, R7)
    stamp_q.delete();
    expect_chg(194, "R9 step 1");
    expect_chg(191, "R9 step 2");
    expect_chg(190, "R5 clamp at min");
    peak_over_hi = 1'b1;
    tick(17); chk("R7 no blank at limit", int'(peak_det_en), 1);
    tick(1);  chk("R7 no blank at limit b", int'(peak_det_en), 1);
    tick(2);
    peak_over_hi = 1'b0;
    chk("R5 final gain", int'(gain_idx), 190);
    chk("R9 strobe count", stamp_q.size(), 3);
    if (stamp_q.size() == 3) begin
      chk("R9 gap 1", stamp_q[1] - stamp_q[0], 5);
      chk("R9 gap 2", stamp_q[2] - stamp_q[1], 5);
    end

    // Increase (R6)
    tick(2);
    expect_chg(192, "R6 increase");
    pwr_up_req = 1'b1; tick(1); pwr_up_req = 1'b0;
    tick(8);

    // Simultaneous requests: decrease wins, increase dropped (R8)
    expect_chg(190, "R8 decrease wins");
    peak_over_hi = 1'b1; pwr_up_req = 1'b1;
    tick(1);
    peak_over_hi = 1'b0; pwr_up_req = 1'b0;
    tick(10);
    chk("R8 increase discarded", int'(gain_idx), 190);

    expect_chg(192, "R6 increase 2");
    pwr_up_req = 1'b1; tick(1); pwr_up_req = 1'b0;
    tick(8);

    // Veto on (R11)
    peak_lo_enough = 1'b1; pwr_up_req = 1'b1;
    tick(1);
    pwr_up_req = 1'b0; peak_lo_enough = 1'b0;
    tick(8);
    chk("R11 vetoed increase", int'(gain_idx), 192);

    // Live config change ignored while active (R2)
    cfg_step_up = 4'd5;
    expect_chg(194, "R2 old step kept");
    pwr_up_req = 1'b1; tick(1); pwr_up_req = 1'b0;
    tick(8);
    chk("R2 frozen config", int'(gain_idx), 194);

    // Setting B: window 195..210, deferred, no veto, no attack
    rx_en = 1'b0;
    cfg_gain_max = 8'd210; cfg_gain_min = 8'd195;
    cfg_step_dn = 4'd5; cfg_step_up = 4'd7;
    cfg_blank = 5'd1; cfg_period = 22'd16; cfg_settle = 7'd2;
    cfg_attack = 6'd0; cfg_sync = 2'b00; cfg_veto_en = 1'b0;
    tick(4);
    chk("R2 new max in idle", int'(gain_idx), 210);
    chk("R1 idle peak_det_en B", int'(peak_det_en), 0);

    rx_en = 1'b1;
    tick(1); chk("R3 zero attack", int'(peak_det_en), 1);
    tick(1);
    expect_chg(205, "R12 deferred decrease");
    peak_over_hi = 1'b1;
    tick(1); peak_over_hi = 1'b0;
    tick(12);
    chk("R12 not yet applied", int'(gain_idx), 210);
    chk("R12 no expiry yet", int'(det_reset), 0);
    tick(1);
    chk("R12 expiry", int'(det_reset), 1);
    chk("R12 no strobe at expiry", int'(gain_chg), 0);
    tick(1);
    chk("R12 strobe after expiry", int'(gain_chg), 1);

    tick(1);
    expect_chg(210, "R11 veto off clamp max");
    peak_lo_enough = 1'b1; pwr_up_req = 1'b1;
    tick(1);
    pwr_up_req = 1'b0; peak_lo_enough = 1'b0;
    tick(13);
    chk("R12 up waits", int'(gain_chg), 0);
    chk("R12 up gain held", int'(gain_idx), 205);
    chk("R12 second expiry", int'(det_reset), 1);
    tick(1);
    chk("R11 gate off strobe", int'(gain_chg), 1);

    // Increase at maximum: no strobe (R7)
    tick(1);
    pwr_up_req = 1'b1; tick(1); pwr_up_req = 1'b0;
    tick(16);
    chk("R7 at max", int'(gain_idx), 210);
    chk("R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule